// File: doc/BRIEF.md
# Vector Instruction Expansion Unit

The unit accepts one decoded three-operand register instruction at a time and breaks it into a run of scalar micro-operations, one per vector element. The micro-operations are offered on a push interface to a downstream FIFO, in ascending element order. A per-register configuration table holds three settings for each of the 32 architectural registers: a vectorised flag, a 4-bit length code and a 16-bit element-enable mask.

When an instruction is accepted, the unit looks up the three operand registers and takes a snapshot of the settings it needs. The destination register supplies the element count and the enable mask. Each operand then steps on its own. A vectorised operand's register number grows by the element index. A scalar operand repeats its number in every micro-operation. Elements whose enable bit is clear are dropped, but the element counter still moves past them. A full FIFO stalls the unit. The instruction input stays not-ready until the whole sequence has been handled.

Top module: `vexp_unit`

## Requirements
- R1: For element i, a vectorised operand (destination or source) is issued as (base + i) modulo 32, so register 30 with i = 3 becomes register 1.
- R2: An operand whose register is not vectorised carries the same register number in every micro-operation of the instruction.
- R3: The element count is the length code of the destination register, and code 0 gives one element. A code of 3 yields exactly three micro-operations when all are enabled.
- R4: Micro-operations are pushed in ascending element order, and `out_elem` gives the element index of each one.
- R5: Bit i of the destination register's 16-bit mask enables element i. An element with a clear bit is never pushed, and the elements after it are still generated. Out of reset every mask is all ones, every register is scalar and every length code is 0.
- R6: A micro-operation is pushed only on a cycle where `out_valid` is high and `fifo_full` is low. While it is held back, its fields stay unchanged, and none is lost or repeated.
- R7: Out of reset `in_ready` is high and `out_valid` is low. After an accepted instruction, `in_ready` stays low until the last element has been pushed or skipped.
- R8: A configuration write made while an instruction is being expanded leaves that instruction's micro-operations unchanged, and it applies to the next accepted instruction.
- R9: The operation code of the instruction is copied unchanged into every micro-operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_reg | input | 5 | Register whose settings are written |
| cfg_vec | input | 1 | Vectorised flag to store |
| cfg_len | input | 4 | Length code to store (0 means one element) |
| cfg_mask | input | 16 | Element-enable mask to store |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Unit idle and able to take an instruction |
| in_op | input | 7 | Operation code |
| in_rd | input | 5 | Destination register base |
| in_rs1 | input | 5 | First source register base |
| in_rs2 | input | 5 | Second source register base |
| out_valid | output | 1 | Micro-operation offered to the FIFO |
| fifo_full | input | 1 | FIFO cannot take a micro-operation this cycle |
| out_op | output | 7 | Operation code of the micro-operation |
| out_rd | output | 5 | Destination register of the micro-operation |
| out_rs1 | output | 5 | First source register of the micro-operation |
| out_rs2 | output | 5 | Second source register of the micro-operation |
| out_elem | output | 4 | Element index of the micro-operation |

## Verification
The assertions assume that `in_valid` is offered with stable operands and that the FIFO's `fifo_full` truthfully reflects whether a push can land. They also assume that nothing downstream needs the micro-operation to change while it is being held back. The stimulus drives every input half a cycle away from the active edge and drops `in_valid` right after the accepting edge. It also drives `fifo_full` in a fixed on/off rhythm during the stall scenario, so the hold and ascending-order properties are exercised under back-pressure as well as free flow.

// File: rtl/vexp_pkg.sv
package vexp_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } vexp_state_e;

  // Number of elements an instruction expands to; code 0 means a single one.
  function automatic int unsigned elem_count(input int unsigned len_code);
    return (len_code == 0) ? 1 : len_code;
  endfunction

endpackage

// File: rtl/vexp_cfg_table.sv
module vexp_cfg_table #(
  parameter int NREG  = 32,
  parameter int RW    = 5,
  parameter int LENW  = 4,
  parameter int MAXEL = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [RW-1:0]    wr_idx,
  input  logic             wr_vec,
  input  logic [LENW-1:0]  wr_len,
  input  logic [MAXEL-1:0] wr_mask,
  input  logic [RW-1:0]    rd_idx [3],
  output logic [2:0]       rd_vec,
  output logic [LENW-1:0]  dst_len,
  output logic [MAXEL-1:0] dst_mask
);

  logic [NREG-1:0]  vec_tab;
  logic [LENW-1:0]  len_tab  [NREG];
  logic [MAXEL-1:0] mask_tab [NREG];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vec_tab <= '0;
      for (int r = 0; r < NREG; r++) begin
        len_tab[r]  <= '0;
        mask_tab[r] <= '1;
      end
    end else if (wr_en) begin
      vec_tab[wr_idx]  <= wr_vec;
      len_tab[wr_idx]  <= wr_len;
      mask_tab[wr_idx] <= wr_mask;
    end
  end

  // One vectorised-flag read port per operand slot (0 = destination).
  for (genvar g = 0; g < 3; g++) begin : g_vec_rd
    assign rd_vec[g] = vec_tab[rd_idx[g]];
  end

  assign dst_len  = len_tab[rd_idx[0]];
  assign dst_mask = mask_tab[rd_idx[0]];

endmodule

// File: rtl/vexp_seq.sv
module vexp_seq
  import vexp_pkg::*;
#(
  parameter int RW    = 5,
  parameter int LENW  = 4,
  parameter int MAXEL = 16,
  parameter int OPW   = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [OPW-1:0]   in_op,
  input  logic [RW-1:0]    in_base [3],
  input  logic [2:0]       lk_vec,
  input  logic [LENW-1:0]  lk_len,
  input  logic [MAXEL-1:0] lk_mask,
  input  logic             fifo_full,
  output logic             out_valid,
  output logic [OPW-1:0]   out_op,
  output logic [RW-1:0]    out_reg [3],
  output logic [LENW-1:0]  out_elem
);

  // Register number of one operand for a given element.
  function automatic logic [RW-1:0] elem_reg(input logic [RW-1:0] base,
                                             input logic vec,
                                             input logic [LENW-1:0] idx);
    logic [RW-1:0] step;
    step = vec ? RW'(idx) : '0;
    return base + step;
  endfunction

  vexp_state_e      state_q;
  logic [LENW-1:0]  idx_q;
  logic [LENW-1:0]  last_q;
  logic [MAXEL-1:0] mask_q;
  logic [OPW-1:0]   op_q;
  logic [RW-1:0]    base_q [3];
  logic [2:0]       vec_q;

  // Named internal events.
  logic busy, accept, elem_on, elem_skip, push_fire, advance, elem_last;

  assign busy      = (state_q == ST_RUN);
  assign in_ready  = !busy;
  assign accept    = in_valid && in_ready;
  assign elem_on   = mask_q[idx_q];
  assign elem_skip = busy && !elem_on;
  assign push_fire = busy && elem_on && !fifo_full;
  assign advance   = elem_skip || push_fire;
  assign elem_last = (idx_q == last_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      last_q  <= '0;
      mask_q  <= '0;
      op_q    <= '0;
      vec_q   <= '0;
      for (int k = 0; k < 3; k++) base_q[k] <= '0;
    end else if (accept) begin
      state_q <= ST_RUN;
      idx_q   <= '0;
      last_q  <= LENW'(elem_count(int'(lk_len)) - 1);
      mask_q  <= lk_mask;
      op_q    <= in_op;
      vec_q   <= lk_vec;
      for (int k = 0; k < 3; k++) base_q[k] <= in_base[k];
    end else if (advance) begin
      if (elem_last) begin
        state_q <= ST_IDLE;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  for (genvar g = 0; g < 3; g++) begin : g_opnd
    assign out_reg[g] = elem_reg(base_q[g], vec_q[g], idx_q);
  end

  assign out_valid = busy && elem_on;
  assign out_op    = op_q;
  assign out_elem  = idx_q;

  // R7: once an instruction is taken, the input is closed next cycle.
  p_ready_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !in_ready);

  // R6: a held-back micro-operation keeps its fields.
  p_hold_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && fifo_full) |=> (out_valid && $stable(out_elem) &&
      $stable(out_reg[0]) && $stable(out_reg[1]) && $stable(out_reg[2]) &&
      $stable(out_op)));

  // R4: element index climbs by exactly one per advance.
  p_ascending_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !elem_last) |=> (busy && out_elem == LENW'($past(out_elem) + 1'b1)));

  // R1: a vectorised destination steps by one register per element, modulo the file.
  p_vec_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !elem_last && vec_q[0]) |=> (out_reg[0] == RW'($past(out_reg[0]) + 1'b1)));

  // R2: a scalar first source never moves within an instruction.
  p_scalar_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !elem_last && !vec_q[1]) |=> $stable(out_reg[1]));

endmodule

// File: rtl/vexp_unit.sv
module vexp_unit #(
  parameter int NREG = 32,
  parameter int LENW = 4,
  parameter int OPW  = 7
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_we,
  input  logic [$clog2(NREG)-1:0] cfg_reg,
  input  logic                    cfg_vec,
  input  logic [LENW-1:0]         cfg_len,
  input  logic [(1<<LENW)-1:0]    cfg_mask,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [OPW-1:0]          in_op,
  input  logic [$clog2(NREG)-1:0] in_rd,
  input  logic [$clog2(NREG)-1:0] in_rs1,
  input  logic [$clog2(NREG)-1:0] in_rs2,
  output logic                    out_valid,
  input  logic                    fifo_full,
  output logic [OPW-1:0]          out_op,
  output logic [$clog2(NREG)-1:0] out_rd,
  output logic [$clog2(NREG)-1:0] out_rs1,
  output logic [$clog2(NREG)-1:0] out_rs2,
  output logic [LENW-1:0]         out_elem
);

  localparam int RW    = $clog2(NREG);
  localparam int MAXEL = 1 << LENW;

  logic [RW-1:0]    base_v [3];
  logic [RW-1:0]    oreg_v [3];
  logic [2:0]       lk_vec;
  logic [LENW-1:0]  lk_len;
  logic [MAXEL-1:0] lk_mask;

  assign base_v[0] = in_rd;
  assign base_v[1] = in_rs1;
  assign base_v[2] = in_rs2;

  vexp_cfg_table #(.NREG(NREG), .RW(RW), .LENW(LENW), .MAXEL(MAXEL)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (cfg_we),
    .wr_idx   (cfg_reg),
    .wr_vec   (cfg_vec),
    .wr_len   (cfg_len),
    .wr_mask  (cfg_mask),
    .rd_idx   (base_v),
    .rd_vec   (lk_vec),
    .dst_len  (lk_len),
    .dst_mask (lk_mask)
  );

  vexp_seq #(.RW(RW), .LENW(LENW), .MAXEL(MAXEL), .OPW(OPW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_op     (in_op),
    .in_base   (base_v),
    .lk_vec    (lk_vec),
    .lk_len    (lk_len),
    .lk_mask   (lk_mask),
    .fifo_full (fifo_full),
    .out_valid (out_valid),
    .out_op    (out_op),
    .out_reg   (oreg_v),
    .out_elem  (out_elem)
  );

  assign out_rd  = oreg_v[0];
  assign out_rs1 = oreg_v[1];
  assign out_rs2 = oreg_v[2];

endmodule

// File: tb/vexp_unit_tb_top.sv
module vexp_unit_tb_top;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_we, cfg_vec;
  logic [4:0] cfg_reg;
  logic [3:0] cfg_len;
  logic [15:0] cfg_mask;
  logic       in_valid, in_ready, out_valid, fifo_full;
  logic [6:0] in_op, out_op;
  logic [4:0] in_rd, in_rs1, in_rs2, out_rd, out_rs1, out_rs2;
  logic [3:0] out_elem;

  int n_tests = 0;
  int n_fail  = 0;

  // Bench's own view of the configuration table.
  bit       m_vec  [32];
  int       m_len  [32];
  bit [15:0] m_mask [32];

  // Pending write issued in the middle of an expansion.
  int mw_reg, mw_len;
  bit mw_vec;
  bit [15:0] mw_mask;

  always #(CLK_PERIOD/2) clk = ~clk;

  vexp_unit dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_reg(cfg_reg), .cfg_vec(cfg_vec), .cfg_len(cfg_len), .cfg_mask(cfg_mask),
    .in_valid(in_valid), .in_ready(in_ready), .in_op(in_op),
    .in_rd(in_rd), .in_rs1(in_rs1), .in_rs2(in_rs2),
    .out_valid(out_valid), .fifo_full(fifo_full), .out_op(out_op),
    .out_rd(out_rd), .out_rs1(out_rs1), .out_rs2(out_rs2), .out_elem(out_elem)
  );

  task automatic check(input bit ok, input string tag, input string what);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: %s", tag, what);
    end
  endtask

  task automatic cfg_write(input int r, input bit v, input int len, input bit [15:0] mask);
    @(negedge clk);
    cfg_we = 1'b1; cfg_reg = 5'(r); cfg_vec = v; cfg_len = 4'(len); cfg_mask = mask;
    @(negedge clk);
    cfg_we = 1'b0;
    m_vec[r] = v; m_len[r] = len; m_mask[r] = mask;
  endtask

  // Issue one instruction, collect its pushes, compare with the bench model.
  task automatic run_instr(input int op, input int rd, input int rs1, input int rs2,
                           input bit stall, input bit midw, input string tag);
    int e_rd[16], e_r1[16], e_r2[16], e_el[16];
    int c_op[16], c_rd[16], c_r1[16], c_r2[16], c_el[16];
    int ne = 0, nc = 0, cnt;
    bit done = 0;
    cnt = (m_len[rd] == 0) ? 1 : m_len[rd];
    for (int i = 0; i < cnt; i++) begin
      if (m_mask[rd][i]) begin
        e_rd[ne] = (rd  + (m_vec[rd]  ? i : 0)) % 32;
        e_r1[ne] = (rs1 + (m_vec[rs1] ? i : 0)) % 32;
        e_r2[ne] = (rs2 + (m_vec[rs2] ? i : 0)) % 32;
        e_el[ne] = i;
        ne++;
      end
    end
    @(negedge clk);
    check(in_ready == 1'b1, "R7", $sformatf("in_ready=%0d before issue, expected 1", in_ready));
    in_valid = 1'b1; in_op = 7'(op); in_rd = 5'(rd); in_rs1 = 5'(rs1); in_rs2 = 5'(rs2);
    @(negedge clk);
    in_valid = 1'b0;
    check(in_ready == 1'b0, "R7", $sformatf("in_ready=%0d after accept, expected 0", in_ready));
    for (int it = 0; it < 200; it++) begin
      if (in_ready) begin done = 1; break; end
      fifo_full = stall ? ((it % 3) != 2) : 1'b0;
      if (out_valid && !fifo_full && nc < 16) begin
        c_op[nc] = out_op; c_rd[nc] = out_rd; c_r1[nc] = out_rs1;
        c_r2[nc] = out_rs2; c_el[nc] = out_elem;
        nc++;
      end
      if (midw && it == 0) begin
        cfg_we = 1'b1; cfg_reg = 5'(mw_reg); cfg_vec = mw_vec;
        cfg_len = 4'(mw_len); cfg_mask = mw_mask;
        m_vec[mw_reg] = mw_vec; m_len[mw_reg] = mw_len; m_mask[mw_reg] = mw_mask;
      end else begin
        cfg_we = 1'b0;
      end
      @(negedge clk);
    end
    fifo_full = 1'b0;
    cfg_we = 1'b0;
    check(done, "R7", "in_ready never returned high");
    check(nc == ne, tag, $sformatf("push count %0d, expected %0d", nc, ne));
    for (int k = 0; k < ne && k < nc; k++) begin
      check(c_op[k] == op && c_rd[k] == e_rd[k] && c_r1[k] == e_r1[k] &&
            c_r2[k] == e_r2[k] && c_el[k] == e_el[k], tag,
            $sformatf("push %0d got op=%0d rd=%0d rs1=%0d rs2=%0d el=%0d, expected op=%0d rd=%0d rs1=%0d rs2=%0d el=%0d",
                      k, c_op[k], c_rd[k], c_r1[k], c_r2[k], c_el[k],
                      op, e_rd[k], e_r1[k], e_r2[k], e_el[k]));
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(in_ready == 1'b1, "R7", $sformatf("reset in_ready=%0d, expected 1", in_ready));
    check(out_valid == 1'b0, "R7", $sformatf("reset out_valid=%0d, expected 0", out_valid));
  endtask

  task automatic t_scalar_pass();
    // R3: length code 0 -> one micro-op; R2 scalar operands unchanged.
    run_instr(5, 7, 4, 4, 1'b0, 1'b0, "R3");
  endtask

  task automatic t_vector_all();
    // R1/R4/R9: three elements, all operands vectorised.
    cfg_write(7, 1'b1, 3, 16'hFFFF);
    cfg_write(4, 1'b1, 0, 16'hFFFF);
    run_instr(51, 7, 4, 4, 1'b0, 1'b0, "R1");
  endtask

  task automatic t_mixed();
    // R2: rs1 scalar (r4 made scalar), rs2 vectorised.
    cfg_write(4, 1'b0, 0, 16'hFFFF);
    cfg_write(1, 1'b1, 0, 16'hFFFF);
    run_instr(51, 7, 4, 1, 1'b0, 1'b0, "R2");
  endtask

  task automatic t_wrap();
    // R1: r30 with four elements reaches r1.
    cfg_write(30, 1'b1, 4, 16'hFFFF);
    cfg_write(31, 1'b1, 0, 16'hFFFF);
    run_instr(9, 30, 31, 0, 1'b0, 1'b0, "R1");
  endtask

  task automatic t_mask();
    // R5: only elements 1, 2, 4 enabled.
    cfg_write(10, 1'b1, 5, 16'b0000_0000_0001_0110);
    run_instr(3, 10, 12, 13, 1'b0, 1'b0, "R5");
    cfg_write(11, 1'b1, 2, 16'h0000);
    run_instr(3, 11, 12, 13, 1'b0, 1'b0, "R5");
  endtask

  task automatic t_stall();
    // R6: back-pressure on every two of three cycles.
    cfg_write(4, 1'b1, 0, 16'hFFFF);
    run_instr(51, 7, 4, 4, 1'b1, 1'b0, "R6");
    run_instr(3, 10, 12, 13, 1'b1, 1'b0, "R6");
  endtask

  task automatic t_mid_cfg();
    // R8: rewrite r7 during its own expansion.
    mw_reg = 7; mw_vec = 1'b1; mw_len = 6; mw_mask = 16'b0000_0000_0011_1011;
    run_instr(20, 7, 4, 4, 1'b0, 1'b1, "R8");
    run_instr(20, 7, 4, 4, 1'b0, 1'b0, "R8");
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_tests++; n_fail++;
    $display("FAIL R7: watchdog expired, got hang, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int r = 0; r < 32; r++) begin
      m_vec[r] = 1'b0; m_len[r] = 0; m_mask[r] = 16'hFFFF;
    end
    rst_n = 1'b0; cfg_we = 1'b0; cfg_reg = '0; cfg_vec = 1'b0; cfg_len = '0; cfg_mask = '0;
    in_valid = 1'b0; in_op = '0; in_rd = '0; in_rs1 = '0; in_rs2 = '0; fifo_full = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_scalar_pass();
    t_vector_all();
    t_mixed();
    t_wrap();
    t_mask();
    t_stall();
    t_mid_cfg();
    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule